// File: doc/BRIEF.md
# OTP Memory Write Command Sequencer

This block is the device-side controller for byte-serial write commands aimed at a one-time-programmable memory. A bus front end, which is not part of this block, hands it whole received bytes, a bus-reset event, a program-pulse event and byte-read requests. The sequencer decodes four write commands: data-array writes and status-array writes, each in a checked form and a fast form. It collects a target address and a data byte and keeps a running CRC-16. When the program pulse arrives, it clears bits in the selected byte. It then returns the programmed byte to the host and moves to the next address.

The checked forms return the inverted CRC before the program pulse, so the host can decide whether to program. The fast forms leave that readback out. The device never acts on the CRC result. After the first byte, each further byte continues at the incremented address. For these bytes the CRC register is loaded with that address instead of being shifted with it. The data array has 2048 bytes and the status array has 32. Both live inside the block, and every write is also visible on a write-port output.

Top module: `otp_write_seq`

## Requirements
- R1: While idle, the first received byte is decoded as a command. 0x0F selects a checked data write, 0xF3 a fast data write, 0x55 a checked status write and 0xF5 a fast status write.
- R2: After a valid command, the next three received bytes are taken in this order: address low byte, address high byte, data byte. Only address bits 10:0 are kept.
- R3: In the checked forms, after the data byte, the first two read requests return the CRC register inverted, low byte first, then high byte. The CRC uses the polynomial x^16+x^15+x^2+1, processes each byte least significant bit first, starts from 0 and covers the command, address low, address high and data bytes.
- R4: In the fast forms, no CRC bytes are sent. After the data byte the block waits for the program pulse, and a read request before the pulse returns nothing (tx_valid stays 0).
- R5: For each continuation byte, the CRC register is loaded with the incremented 11-bit address, zero-extended to 16 bits, and only the new data byte is then shifted in.
- R6: Unprogrammed cells read 0xFF. A program pulse in the waiting state raises mem_we for that cycle and stores old AND data, whatever the CRC outcome.
- R7: After programming, the next read request returns the byte now stored at that location. The address then advances by one and the next received byte is the next data byte.
- R8: The data address wraps from 2047 to 0 on a continuation.
- R9: Status writes use address bits 4:0 to pick one of 32 status bytes. These are held apart from the data array.
- R10: A bus reset in any state aborts the command. It returns the block to idle without programming, so a later program pulse writes nothing.
- R11: An unknown command byte makes the block ignore all received bytes, program pulses and read requests until the next bus reset.
- R12: After reset tx_valid and mem_we are 0. A read request in a read state gives tx_valid with tx_byte on the following cycle. Program pulses outside the waiting state and bytes received while a read or pulse is awaited have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (also restores unprogrammed arrays) |
| rx_valid | input | 1 | One-cycle strobe: rx_byte holds a received byte |
| rx_byte | input | 8 | Received byte |
| bus_reset | input | 1 | One-cycle bus reset event, aborts any command |
| prog_pulse | input | 1 | One-cycle program pulse event |
| rd_req | input | 1 | One-cycle request for the next byte to transmit |
| tx_valid | output | 1 | tx_byte is valid this cycle |
| tx_byte | output | 8 | Byte to transmit |
| mem_we | output | 1 | Write strobe into the selected array |
| mem_status | output | 1 | Write targets the status array |
| mem_addr | output | 11 | Write address |
| mem_wdata | output | 8 | Value written (old AND data) |

## Verification
A byte asked for by rd_req appears on tx_byte with tx_valid exactly one cycle after the edge that samples the request. The driver therefore holds rd_req for one cycle and queues the expected byte first, and the monitor compares at the falling edge that follows. The write strobe is a function of the current state and prog_pulse, so it is counted at the same edge that samples the pulse. Every check of a write (or of a missing write) reads that count once the pulse cycle has ended. Ignored stimuli are shown to have no effect by reading the array afterwards through a fast write of 0xFF, which returns the stored byte unchanged.

// File: rtl/otp_wr_pkg.sv
package otp_wr_pkg;

    localparam int BYTE_W = 8;
    localparam int CRC_W  = 16;

    localparam logic [BYTE_W-1:0] CMD_WMEM       = 8'h0F;
    localparam logic [BYTE_W-1:0] CMD_WMEM_FAST  = 8'hF3;
    localparam logic [BYTE_W-1:0] CMD_WSTAT      = 8'h55;
    localparam logic [BYTE_W-1:0] CMD_WSTAT_FAST = 8'hF5;

    // x^16 + x^15 + x^2 + 1, bit-reversed for LSB-first shifting
    localparam logic [CRC_W-1:0] CRC_POLY_REFL = 16'hA001;

    typedef enum logic [3:0] {
        ST_CMD,
        ST_ALO,
        ST_AHI,
        ST_DATA,
        ST_CRC0,
        ST_CRC1,
        ST_PROG,
        ST_VFY,
        ST_HALT
    } seq_state_t;

    typedef enum logic [1:0] {
        CRC_HOLD,
        CRC_SHIFT,
        CRC_FRESH,
        CRC_LOAD
    } crc_op_t;

    typedef struct packed {
        logic known;
        logic fast;
        logic status;
    } cmd_info_t;

    function automatic cmd_info_t decode_cmd(input logic [BYTE_W-1:0] b);
        cmd_info_t r;
        r = '0;
        case (b)
            CMD_WMEM:       r = '{known: 1'b1, fast: 1'b0, status: 1'b0};
            CMD_WMEM_FAST:  r = '{known: 1'b1, fast: 1'b1, status: 1'b0};
            CMD_WSTAT:      r = '{known: 1'b1, fast: 1'b0, status: 1'b1};
            CMD_WSTAT_FAST: r = '{known: 1'b1, fast: 1'b1, status: 1'b1};
            default:        r = '0;
        endcase
        return r;
    endfunction

    function automatic logic [CRC_W-1:0] crc16_byte(input logic [CRC_W-1:0] c,
                                                    input logic [BYTE_W-1:0] d);
        logic [CRC_W-1:0] r;
        r = c;
        for (int i = 0; i < BYTE_W; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_REFL;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/otp_wr_crc.sv
module otp_wr_crc
    import otp_wr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  crc_op_t          op,
    input  logic [BYTE_W-1:0] din,
    input  logic [CRC_W-1:0] seed,
    output logic [CRC_W-1:0] crc
);

    always_ff @(posedge clk) begin
        if (rst) begin
            crc <= '0;
        end else begin
            case (op)
                CRC_SHIFT: crc <= crc16_byte(crc, din);
                CRC_FRESH: crc <= crc16_byte('0, din);
                CRC_LOAD:  crc <= seed;
                default:   crc <= crc;
            endcase
        end
    end

    // R5: a continuation seeds the register with the address, unshifted
    a_r5_seed_loaded: assert property (@(posedge clk) disable iff (rst)
        (op == CRC_LOAD) |=> (crc == $past(seed)));

    // R3: the register only moves on an explicit operation
    a_r3_crc_holds: assert property (@(posedge clk) disable iff (rst)
        (op == CRC_HOLD) |=> $stable(crc));

endmodule

// File: rtl/otp_wr_store.sv
module otp_wr_store
    import otp_wr_pkg::*;
#(
    parameter int AW         = 11,
    parameter int STAT_DEPTH = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              sel_stat,
    input  logic [AW-1:0]     addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rd_data
);

    localparam int DATA_DEPTH = 1 << AW;
    localparam int SW         = $clog2(STAT_DEPTH);

    logic [BYTE_W-1:0] data_mem [DATA_DEPTH];
    logic [BYTE_W-1:0] stat_mem [STAT_DEPTH];
    logic [SW-1:0]     stat_idx;

    assign stat_idx = addr[SW-1:0];
    assign rd_data  = sel_stat ? stat_mem[stat_idx] : data_mem[addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DATA_DEPTH; i++) data_mem[i] <= '1;
        end else if (we && !sel_stat) begin
            data_mem[addr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAT_DEPTH; i++) stat_mem[i] <= '1;
        end else if (we && sel_stat) begin
            stat_mem[stat_idx] <= wdata;
        end
    end

    // R6: a write may only clear bits of the cell it replaces
    a_r6_only_clear: assert property (@(posedge clk) disable iff (rst)
        we |-> ((wdata & ~rd_data) == '0));

endmodule

// File: rtl/otp_write_seq.sv
module otp_write_seq
    import otp_wr_pkg::*;
#(
    parameter int DATA_AW    = 11,
    parameter int STAT_DEPTH = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rx_valid,
    input  logic [7:0]         rx_byte,
    input  logic               bus_reset,
    input  logic               prog_pulse,
    input  logic               rd_req,
    output logic               tx_valid,
    output logic [7:0]         tx_byte,
    output logic               mem_we,
    output logic               mem_status,
    output logic [DATA_AW-1:0] mem_addr,
    output logic [7:0]         mem_wdata
);

    localparam int ADDR_FULL_W = 2 * BYTE_W;

    seq_state_t              state_q;
    cmd_info_t               cmd_q;
    cmd_info_t               rx_cmd;
    logic [DATA_AW-1:0]      addr_q;
    logic [DATA_AW-1:0]      addr_inc;
    logic [ADDR_FULL_W-1:0]  addr_full;
    logic [BYTE_W-1:0]       data_q;
    logic [BYTE_W-1:0]       rd_data;
    logic [CRC_W-1:0]        crc_val;
    logic [CRC_W-1:0]        crc_seed;
    crc_op_t                 crc_op;

    always_comb begin
        rx_cmd    = decode_cmd(rx_byte);
        addr_full = {rx_byte, addr_q[BYTE_W-1:0]};
        addr_inc  = addr_q + 1'b1;
        crc_seed  = {{(CRC_W-DATA_AW){1'b0}}, addr_inc};
    end

    always_comb begin
        crc_op = CRC_HOLD;
        if (!bus_reset) begin
            case (state_q)
                ST_CMD:  if (rx_valid && rx_cmd.known) crc_op = CRC_FRESH;
                ST_ALO,
                ST_AHI,
                ST_DATA: if (rx_valid) crc_op = CRC_SHIFT;
                ST_VFY:  if (rd_req) crc_op = CRC_LOAD;
                default: crc_op = CRC_HOLD;
            endcase
        end
    end

    assign mem_we     = !bus_reset && (state_q == ST_PROG) && prog_pulse;
    assign mem_status = cmd_q.status;
    assign mem_addr   = addr_q;
    assign mem_wdata  = rd_data & data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_CMD;
            cmd_q    <= '0;
            addr_q   <= '0;
            data_q   <= '1;
            tx_valid <= 1'b0;
            tx_byte  <= '0;
        end else begin
            tx_valid <= 1'b0;
            if (bus_reset) begin
                state_q <= ST_CMD;
            end else begin
                case (state_q)
                    ST_CMD: if (rx_valid) begin
                        if (rx_cmd.known) begin
                            cmd_q   <= rx_cmd;
                            state_q <= ST_ALO;
                        end else begin
                            state_q <= ST_HALT;
                        end
                    end
                    ST_ALO: if (rx_valid) begin
                        addr_q[BYTE_W-1:0] <= rx_byte;
                        state_q            <= ST_AHI;
                    end
                    ST_AHI: if (rx_valid) begin
                        addr_q  <= addr_full[DATA_AW-1:0];
                        state_q <= ST_DATA;
                    end
                    ST_DATA: if (rx_valid) begin
                        data_q  <= rx_byte;
                        state_q <= cmd_q.fast ? ST_PROG : ST_CRC0;
                    end
                    ST_CRC0: if (rd_req) begin
                        tx_valid <= 1'b1;
                        tx_byte  <= ~crc_val[BYTE_W-1:0];
                        state_q  <= ST_CRC1;
                    end
                    ST_CRC1: if (rd_req) begin
                        tx_valid <= 1'b1;
                        tx_byte  <= ~crc_val[CRC_W-1:BYTE_W];
                        state_q  <= ST_PROG;
                    end
                    ST_PROG: if (prog_pulse) begin
                        state_q <= ST_VFY;
                    end
                    ST_VFY: if (rd_req) begin
                        tx_valid <= 1'b1;
                        tx_byte  <= rd_data;
                        addr_q   <= addr_inc;
                        state_q  <= ST_DATA;
                    end
                    ST_HALT: state_q <= ST_HALT;
                    default: state_q <= ST_CMD;
                endcase
            end
        end
    end

    otp_wr_crc u_crc (
        .clk  (clk),
        .rst  (rst),
        .op   (crc_op),
        .din  (rx_byte),
        .seed (crc_seed),
        .crc  (crc_val)
    );

    otp_wr_store #(
        .AW         (DATA_AW),
        .STAT_DEPTH (STAT_DEPTH)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .we       (mem_we),
        .sel_stat (mem_status),
        .addr     (addr_q),
        .wdata    (mem_wdata),
        .rd_data  (rd_data)
    );

    // R10: a bus reset always lands in idle
    a_r10_reset_to_idle: assert property (@(posedge clk) disable iff (rst)
        bus_reset |=> (state_q == ST_CMD));

    // R7: every write is followed by the readback state
    a_r7_verify_after_write: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (state_q == ST_VFY));

    // R7 / R8: readback advances the address by one, wrapping
    a_r8_addr_step: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_VFY && rd_req && !bus_reset) |=> (addr_q == $past(addr_q) + 1'b1));

    // R11: the halt state is left only through a bus reset
    a_r11_halt_sticky: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HALT && !bus_reset) |=> (state_q == ST_HALT));

    // R4: fast forms go straight from data to the pulse wait
    a_r4_fast_skips_crc: assert property (@(posedge clk) disable iff (rst)
        (cmd_q.fast && state_q == ST_DATA && rx_valid && !bus_reset) |=> (state_q == ST_PROG));

    // R12: nothing is sent without a request the cycle before
    a_r12_tx_needs_req: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> $past(rd_req));

endmodule

// File: tb/sim_otp_write_seq.sv
module sim_otp_write_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        bus_reset = 1'b0;
    logic        prog_pulse = 1'b0;
    logic        rd_req = 1'b0;
    logic        tx_valid;
    logic [7:0]  tx_byte;
    logic        mem_we;
    logic        mem_status;
    logic [10:0] mem_addr;
    logic [7:0]  mem_wdata;

    always #10 clk = ~clk;

    otp_write_seq u0 (
        .clk        (clk),
        .rst        (rst),
        .rx_valid   (rx_valid),
        .rx_byte    (rx_byte),
        .bus_reset  (bus_reset),
        .prog_pulse (prog_pulse),
        .rd_req     (rd_req),
        .tx_valid   (tx_valid),
        .tx_byte    (tx_byte),
        .mem_we     (mem_we),
        .mem_status (mem_status),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata)
    );

    int checks = 0;
    int errors = 0;
    int we_count = 0;
    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic [7:0] mon_e;
    string      mon_t;

    logic [7:0]  m_data [2048];
    logic [7:0]  m_stat [32];
    logic [15:0] m_crc;
    logic [10:0] m_addr;
    bit          m_fast;
    bit          m_stsel;

    task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (((r ^ {8'h00, d >> i}) & 16'h0001) != 0) r = (r >> 1) ^ 16'hA001;
            else r = r >> 1;
        end
        return r;
    endfunction

    always @(posedge clk) if (!rst && mem_we) we_count++;

    // monitor: pops expected bytes as the design sends them
    always @(negedge clk) begin
        if (!rst && tx_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R12", tx_byte, 0, "unrequested tx byte");
            end else begin
                mon_e = exp_q.pop_front();
                mon_t = tag_q.pop_front();
                chk(tx_byte == mon_e, mon_t, tx_byte, mon_e, "tx byte");
            end
        end
    end

    task automatic send(input logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_byte = b;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic pulse();
        @(negedge clk); prog_pulse = 1'b1;
        @(negedge clk); prog_pulse = 1'b0;
    endtask

    task automatic breset();
        @(negedge clk); bus_reset = 1'b1;
        @(negedge clk); bus_reset = 1'b0;
    endtask

    task automatic rd(input logic [7:0] e, input string tag);
        @(negedge clk);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        rd_req = 1'b1;
        @(negedge clk); rd_req = 1'b0;
    endtask

    task automatic rd_none(input string tag);
        @(negedge clk); rd_req = 1'b1;
        @(negedge clk); rd_req = 1'b0;
        chk(tx_valid == 1'b0, tag, tx_valid, 0, "read answered while not allowed");
    endtask

    task automatic begin_cmd(input logic [7:0] cmd, input logic [15:0] a);
        send(cmd);
        send(a[7:0]);
        send(a[15:8]);
        m_crc   = ref_crc(ref_crc(ref_crc(16'h0000, cmd), a[7:0]), a[15:8]);
        m_addr  = a[10:0];
        m_fast  = (cmd == 8'hF3) || (cmd == 8'hF5);
        m_stsel = (cmd == 8'h55) || (cmd == 8'hF5);
    endtask

    task automatic prog_byte(input logic [7:0] d, input string tag);
        logic [7:0] e;
        int w0;
        send(d);
        m_crc = ref_crc(m_crc, d);
        if (!m_fast) begin
            rd(~m_crc[7:0], "R3");
            rd(~m_crc[15:8], "R3");
        end
        w0 = we_count;
        pulse();
        chk(we_count == w0 + 1, "R6", we_count, w0 + 1, "write strobe count");
        if (m_stsel) begin
            m_stat[m_addr[4:0]] = m_stat[m_addr[4:0]] & d;
            e = m_stat[m_addr[4:0]];
        end else begin
            m_data[m_addr] = m_data[m_addr] & d;
            e = m_data[m_addr];
        end
        rd(e, tag);
        m_addr = m_addr + 11'd1;
        m_crc  = {5'b00000, m_addr};
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int w0;
        for (int i = 0; i < 2048; i++) m_data[i] = 8'hFF;
        for (int i = 0; i < 32; i++) m_stat[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(tx_valid == 1'b0 && mem_we == 1'b0, "R12", {tx_valid, mem_we}, 0, "reset outputs");

        // R1 R2 R3 R6 R7: checked data write with continuations (R5)
        begin_cmd(8'h0F, 16'h0123);
        prog_byte(8'hA5, "R7");
        prog_byte(8'h3C, "R5");
        prog_byte(8'hFF, "R5");
        breset();

        // R4: fast data write, early read returns nothing
        begin_cmd(8'hF3, 16'h0200);
        send(8'h12);
        rd_none("R4");
        m_crc = ref_crc(m_crc, 8'h12);
        pulse();
        m_data[11'h200] = 8'h12;
        rd(8'h12, "R4");
        breset();

        // R8: wrap from 2047 to 0, upper address bits dropped (R2)
        begin_cmd(8'hF3, 16'hF7FF);
        prog_byte(8'hF0, "R2");
        prog_byte(8'h0F, "R8");
        breset();

        // R9: status write and separation from data array
        begin_cmd(8'h55, 16'h0025);
        prog_byte(8'h81, "R9");
        breset();
        begin_cmd(8'hF5, 16'h0005);
        prog_byte(8'hFF, "R9");
        breset();
        begin_cmd(8'hF3, 16'h0005);
        prog_byte(8'hFF, "R9");
        breset();

        // R6: AND semantics on an already programmed cell
        begin_cmd(8'h0F, 16'h0123);
        prog_byte(8'h0F, "R6");
        breset();

        // R10: abort after CRC, pulse must not program
        begin_cmd(8'h0F, 16'h0300);
        send(8'h00);
        m_crc = ref_crc(m_crc, 8'h00);
        rd(~m_crc[7:0], "R3");
        rd(~m_crc[15:8], "R3");
        breset();
        w0 = we_count;
        pulse();
        chk(we_count == w0, "R10", we_count, w0, "write after abort");
        begin_cmd(8'hF3, 16'h0300);
        prog_byte(8'hFF, "R10");
        breset();

        // R10: abort mid-address, next byte is a command again
        send(8'h0F);
        send(8'h40);
        breset();
        begin_cmd(8'hF3, 16'h0041);
        prog_byte(8'h77, "R10");
        breset();

        // R11: unknown command locks out until bus reset
        send(8'h99);
        send(8'h0F);
        send(8'h00);
        send(8'h06);
        send(8'h00);
        w0 = we_count;
        pulse();
        chk(we_count == w0, "R11", we_count, w0, "write while halted");
        rd_none("R11");
        breset();
        begin_cmd(8'h0F, 16'h0600);
        prog_byte(8'h5A, "R11");
        breset();

        // R12: pulse before address ignored, stray byte during pulse wait ignored
        send(8'hF3);
        w0 = we_count;
        pulse();
        chk(we_count == w0, "R12", we_count, w0, "early pulse write");
        send(8'h00);
        send(8'h05);
        send(8'h3C);
        send(8'h00);
        pulse();
        m_data[11'h500] = 8'h3C;
        rd(8'h3C, "R12");
        breset();

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R12", exp_q.size(), 0, "bytes still owed");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule